// File: doc/BRIEF.md
# Narrow-to-wide registered bus exchanger

This block joins a 12-bit port A to a 24-bit port B. Port B is split into two 12-bit halves, 1B and 2B. Going from A to B, the block collects two narrow words from A on consecutive clock edges and presents them side by side as one wide word. The first word appears on half 1B and the second on half 2B. Going from B to A, each half of port B is stored in its own register, and a registered select picks which stored half drives port A.

Each of the four storage paths has its own active-low clock enable:
- A into 1B
- A into 2B
- 1B into A
- 2B into A

The A-into-1B path is two registers deep and the A-into-2B path is one register deep. Because of that difference, sequencing the enables correctly brings a word pair into line on port B.

The port output enables are active low and registered, so a change of bus direction takes effect only at a clock edge. Each port presents a data bus and a drive flag instead of real tri-state pins. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `xchg_bus_widener`

## Requirements
- R1: While reset is held, all data outputs read zero and all drive flags read 0 (not driven).
- R2: On a rising edge with `a2b1_ce_n` low, the first 1B stage captures `a_data_i`, and the second 1B stage, which drives `b1_data_o`, captures the first stage's old value. A word therefore reaches `b1_data_o` after two enabled edges.
- R3: On a rising edge with `a2b2_ce_n` low, `b2_data_o` takes the value `a_data_i` had before that edge (one-edge latency).
- R4: Suppose word W0 is presented with only `a2b1_ce_n` low, and then word W1 is presented with both A-side enables low. After the second edge, `b1_data_o` equals W0 and `b2_data_o` equals W1 in the same cycle.
- R5: While a path's enable is high, its register keeps its value whatever its data input does. This applies to both 1B stages, the 2B register and both B-to-A registers.
- R6: On a rising edge with `b2a1_ce_n` low, the 1B-to-A register captures `b1_data_i`. On a rising edge with `b2a2_ce_n` low, the 2B-to-A register captures `b2_data_i`.
- R7: `half_sel_i` is sampled on every rising edge, with no enable. A sampled 0 makes `a_data_o` show the stored 1B value, and a sampled 1 makes it show the stored 2B value. A change of select reaches `a_data_o` one edge later.
- R8: The drive flags are the inverse of `a_oe_n_i` and `b_oe_n_i` as sampled at the last rising edge. A change on an output-enable input has no effect on the flags before the next edge. `b1_drive_o` and `b2_drive_o` always follow the single registered B enable together.
- R9: Asserting `rst_ni` clears every output immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers capture on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_data_i | input | 12 | Narrow word arriving on port A |
| a2b1_ce_n_i | input | 1 | Active-low enable for both A-to-1B stages |
| a2b2_ce_n_i | input | 1 | Active-low enable for the A-to-2B register |
| b1_data_i | input | 12 | Half 1B arriving on port B |
| b2_data_i | input | 12 | Half 2B arriving on port B |
| b2a1_ce_n_i | input | 1 | Active-low enable for the 1B-to-A register |
| b2a2_ce_n_i | input | 1 | Active-low enable for the 2B-to-A register |
| half_sel_i | input | 1 | Select for port A: 0 picks stored 1B, 1 picks stored 2B |
| a_oe_n_i | input | 1 | Active-low output enable for port A, registered |
| b_oe_n_i | input | 1 | Active-low output enable for port B, registered |
| a_data_o | output | 12 | Data driven onto port A |
| a_drive_o | output | 1 | 1 when port A is driven |
| b1_data_o | output | 12 | Data driven onto half 1B |
| b2_data_o | output | 12 | Data driven onto half 2B |
| b1_drive_o | output | 1 | 1 when half 1B is driven |
| b2_drive_o | output | 1 | 1 when half 2B is driven |

## Verification
The hardest situation to reach from the ports is the one where the 1B pipeline holds two different words in its two stages while the 2B register holds a third word. Only then does a slip of one stage show up on the outputs. The stimulus gets there by running the A-side enables in the pair pattern with distinct words, and then interleaving edges where only one A-side enable is low. A cycle-accurate model in the bench follows every register, so each intermediate state is compared, not just the aligned pair.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned NARROW_W = 12;
  localparam int unsigned HALVES   = 2;
  localparam int unsigned WIDE_W   = NARROW_W * HALVES;

  typedef enum logic {
    HALF_1B = 1'b0,
    HALF_2B = 1'b1
  } half_sel_e;
endpackage

// File: rtl/xchg_rst_sync.sv
module xchg_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[DEPTH-1];
endmodule

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
  parameter int unsigned    W       = 12,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    if (ce_ni) q_d = q_q;
    else       q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/xchg_a2b.sv
module xchg_a2b #(
  parameter int unsigned W        = 12,
  parameter int unsigned DEPTH_1B = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce1_ni,
  input  logic         ce2_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] mid_o,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  logic [W-1:0] pipe [0:DEPTH_1B];

  assign pipe[0] = a_i;

  for (genvar g = 0; g < DEPTH_1B; g++) begin : g_stage
    xchg_en_reg #(.W(W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ce_ni (ce1_ni),
      .d_i   (pipe[g]),
      .q_o   (pipe[g+1])
    );
  end

  xchg_en_reg #(.W(W)) u_r2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce2_ni),
    .d_i   (a_i),
    .q_o   (b2_o)
  );

  assign mid_o = pipe[1];
  assign b1_o  = pipe[DEPTH_1B];
endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a
  import xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce1_ni,
  input  logic         ce2_ni,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  input  half_sel_e    sel_i,
  output logic [W-1:0] st1_o,
  output logic [W-1:0] st2_o,
  output logic [W-1:0] a_o
);
  xchg_en_reg #(.W(W)) u_st1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce1_ni),
    .d_i   (b1_i),
    .q_o   (st1_o)
  );

  xchg_en_reg #(.W(W)) u_st2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce2_ni),
    .d_i   (b2_i),
    .q_o   (st2_o)
  );

  always_comb begin
    unique case (sel_i)
      HALF_2B: a_o = st2_o;
      default: a_o = st1_o;
    endcase
  end
endmodule

// File: rtl/xchg_ctl.sv
module xchg_ctl
  import xchg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sel_i,
  input  logic      a_oe_ni,
  input  logic      b_oe_ni,
  output half_sel_e sel_o,
  output logic      a_drive_o,
  output logic      b_drive_o
);
  logic [2:0] ctl_q;

  xchg_en_reg #(.W(3), .RST_VAL(3'b110)) u_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (1'b0),
    .d_i   ({a_oe_ni, b_oe_ni, sel_i}),
    .q_o   (ctl_q)
  );

  assign sel_o     = half_sel_e'(ctl_q[0]);
  assign b_drive_o = ~ctl_q[1];
  assign a_drive_o = ~ctl_q[2];
endmodule

// File: rtl/xchg_bus_widener.sv
module xchg_bus_widener
  import xchg_pkg::*;
#(
  parameter int unsigned W        = NARROW_W,
  parameter int unsigned DEPTH_1B = 2,
  parameter int unsigned SYNC_D   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_data_i,
  input  logic         a2b1_ce_n_i,
  input  logic         a2b2_ce_n_i,
  input  logic [W-1:0] b1_data_i,
  input  logic [W-1:0] b2_data_i,
  input  logic         b2a1_ce_n_i,
  input  logic         b2a2_ce_n_i,
  input  logic         half_sel_i,
  input  logic         a_oe_n_i,
  input  logic         b_oe_n_i,
  output logic [W-1:0] a_data_o,
  output logic         a_drive_o,
  output logic [W-1:0] b1_data_o,
  output logic [W-1:0] b2_data_o,
  output logic         b1_drive_o,
  output logic         b2_drive_o
);
  logic         rst_sync_n;
  logic [W-1:0] a2b_mid;
  logic [W-1:0] st1;
  logic [W-1:0] st2;
  half_sel_e    sel_q;
  logic         b_drive;

  xchg_rst_sync #(.DEPTH(SYNC_D)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  xchg_a2b #(.W(W), .DEPTH_1B(DEPTH_1B)) u_a2b (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .ce1_ni(a2b1_ce_n_i),
    .ce2_ni(a2b2_ce_n_i),
    .a_i   (a_data_i),
    .mid_o (a2b_mid),
    .b1_o  (b1_data_o),
    .b2_o  (b2_data_o)
  );

  xchg_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sel_i    (half_sel_i),
    .a_oe_ni  (a_oe_n_i),
    .b_oe_ni  (b_oe_n_i),
    .sel_o    (sel_q),
    .a_drive_o(a_drive_o),
    .b_drive_o(b_drive)
  );

  xchg_b2a #(.W(W)) u_b2a (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .ce1_ni(b2a1_ce_n_i),
    .ce2_ni(b2a2_ce_n_i),
    .b1_i  (b1_data_i),
    .b2_i  (b2_data_i),
    .sel_i (sel_q),
    .st1_o (st1),
    .st2_o (st2),
    .a_o   (a_data_o)
  );

  assign b1_drive_o = b_drive;
  assign b2_drive_o = b_drive;
endmodule

// File: rtl/xchg_bus_widener_chk.sv
module xchg_bus_widener_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rst_sync_n,
  input logic [W-1:0] a_data_i,
  input logic         a2b1_ce_n_i,
  input logic         a2b2_ce_n_i,
  input logic [W-1:0] b1_data_i,
  input logic [W-1:0] b2_data_i,
  input logic         b2a1_ce_n_i,
  input logic         b2a2_ce_n_i,
  input logic         half_sel_i,
  input logic         a_oe_n_i,
  input logic         b_oe_n_i,
  input logic [W-1:0] a2b_mid,
  input logic [W-1:0] st1,
  input logic [W-1:0] st2,
  input logic [W-1:0] a_data_o,
  input logic         a_drive_o,
  input logic [W-1:0] b1_data_o,
  input logic [W-1:0] b2_data_o,
  input logic         b1_drive_o,
  input logic         b2_drive_o
);
  p_undriven_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_sync_n |-> (!a_drive_o && !b1_drive_o && !b2_drive_o));

  p_stage_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !a2b1_ce_n_i |=> (b1_data_o == $past(a2b_mid)));

  p_stage_load_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !a2b1_ce_n_i |=> (a2b_mid == $past(a_data_i)));

  p_wide_load_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !a2b2_ce_n_i |=> (b2_data_o == $past(a_data_i)));

  p_hold_1b_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    a2b1_ce_n_i |=> ($stable(b1_data_o) && $stable(a2b_mid)));

  p_hold_2b_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    a2b2_ce_n_i |=> $stable(b2_data_o));

  p_ret1_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !b2a1_ce_n_i |=> (st1 == $past(b1_data_i)));

  p_ret2_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !b2a2_ce_n_i |=> (st2 == $past(b2_data_i)));

  p_select_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (a_data_o == ($past(half_sel_i) ? st2 : st1)));

  p_oe_a_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (a_drive_o == !$past(a_oe_n_i)));

  p_oe_b_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (b2_drive_o == !$past(b_oe_n_i)));
endmodule

bind xchg_bus_widener xchg_bus_widener_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_n (rst_sync_n),
  .a_data_i   (a_data_i),
  .a2b1_ce_n_i(a2b1_ce_n_i),
  .a2b2_ce_n_i(a2b2_ce_n_i),
  .b1_data_i  (b1_data_i),
  .b2_data_i  (b2_data_i),
  .b2a1_ce_n_i(b2a1_ce_n_i),
  .b2a2_ce_n_i(b2a2_ce_n_i),
  .half_sel_i (half_sel_i),
  .a_oe_n_i   (a_oe_n_i),
  .b_oe_n_i   (b_oe_n_i),
  .a2b_mid    (a2b_mid),
  .st1        (st1),
  .st2        (st2),
  .a_data_o   (a_data_o),
  .a_drive_o  (a_drive_o),
  .b1_data_o  (b1_data_o),
  .b2_data_o  (b2_data_o),
  .b1_drive_o (b1_drive_o),
  .b2_drive_o (b2_drive_o)
);

// File: tb/sim_xchg_bus_widener.sv
module sim_xchg_bus_widener;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [11:0] a_data_i, b1_data_i, b2_data_i;
  logic        a2b1_ce_n_i, a2b2_ce_n_i, b2a1_ce_n_i, b2a2_ce_n_i;
  logic        half_sel_i, a_oe_n_i, b_oe_n_i;
  logic [11:0] a_data_o, b1_data_o, b2_data_o;
  logic        a_drive_o, b1_drive_o, b2_drive_o;

  int checks = 0;
  int errors = 0;

  logic [11:0] m_s1, m_s2, m_r2, m_q1, m_q2;
  logic        m_sel, m_aoe, m_boe;

  always #4 clk_i = ~clk_i;

  xchg_bus_widener u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_data_i(a_data_i), .a2b1_ce_n_i(a2b1_ce_n_i), .a2b2_ce_n_i(a2b2_ce_n_i),
    .b1_data_i(b1_data_i), .b2_data_i(b2_data_i),
    .b2a1_ce_n_i(b2a1_ce_n_i), .b2a2_ce_n_i(b2a2_ce_n_i),
    .half_sel_i(half_sel_i), .a_oe_n_i(a_oe_n_i), .b_oe_n_i(b_oe_n_i),
    .a_data_o(a_data_o), .a_drive_o(a_drive_o),
    .b1_data_o(b1_data_o), .b2_data_o(b2_data_o),
    .b1_drive_o(b1_drive_o), .b2_drive_o(b2_drive_o)
  );

  task automatic chk(string req, string what, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_r2 = '0; m_q1 = '0; m_q2 = '0;
    m_sel = 1'b0; m_aoe = 1'b1; m_boe = 1'b1;
  endtask

  task automatic idle_inputs();
    a2b1_ce_n_i = 1'b1; a2b2_ce_n_i = 1'b1; b2a1_ce_n_i = 1'b1; b2a2_ce_n_i = 1'b1;
    half_sel_i = 1'b0; a_oe_n_i = 1'b1; b_oe_n_i = 1'b1;
    a_data_i = '0; b1_data_i = '0; b2_data_i = '0;
  endtask

  task automatic tick();
    logic [11:0] n_s1, n_s2, n_r2, n_q1, n_q2;
    n_s1 = a2b1_ce_n_i ? m_s1 : a_data_i;
    n_s2 = a2b1_ce_n_i ? m_s2 : m_s1;
    n_r2 = a2b2_ce_n_i ? m_r2 : a_data_i;
    n_q1 = b2a1_ce_n_i ? m_q1 : b1_data_i;
    n_q2 = b2a2_ce_n_i ? m_q2 : b2_data_i;
    @(posedge clk_i);
    #1;
    m_s1 = n_s1; m_s2 = n_s2; m_r2 = n_r2; m_q1 = n_q1; m_q2 = n_q2;
    m_sel = half_sel_i; m_aoe = a_oe_n_i; m_boe = b_oe_n_i;
  endtask

  task automatic check_model(string req);
    chk(req, "b1_data_o", b1_data_o, m_s2);
    chk(req, "b2_data_o", b2_data_o, m_r2);
    chk(req, "a_data_o", a_data_o, m_sel ? m_q2 : m_q1);
    chk(req, "a_drive_o", {11'd0, a_drive_o}, {11'd0, !m_aoe});
    chk(req, "b1_drive_o", {11'd0, b1_drive_o}, {11'd0, !m_boe});
    chk(req, "b2_drive_o", {11'd0, b2_drive_o}, {11'd0, !m_boe});
  endtask

  task automatic check_all_zero(string req);
    chk(req, "a_data_o", a_data_o, '0);
    chk(req, "b1_data_o", b1_data_o, '0);
    chk(req, "b2_data_o", b2_data_o, '0);
    chk(req, "drive flags", {9'd0, a_drive_o, b1_drive_o, b2_drive_o}, '0);
  endtask

  task automatic release_reset();
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    model_reset();
  endtask

  // R1: reset state
  task automatic t_reset();
    idle_inputs();
    rst_ni = 1'b0;
    model_reset();
    #17;
    check_all_zero("R1");
    release_reset();
    check_model("R1");
  endtask

  // R2 R3 R4: word pairing across the two A-side paths
  task automatic t_pairing();
    logic [11:0] w0, w1;
    b_oe_n_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      w0 = 12'h1A0 + 12'(k * 17);
      w1 = 12'hC05 - 12'(k * 33);
      a_data_i = w0; a2b1_ce_n_i = 1'b0; a2b2_ce_n_i = 1'b1;
      tick();
      check_model("R2");
      a_data_i = w1; a2b2_ce_n_i = 1'b0;
      tick();
      chk("R4", "b1 pair word", b1_data_o, w0);
      chk("R4", "b2 pair word", b2_data_o, w1);
      check_model("R3");
    end
    // interleaved single-path edges: stages hold distinct words
    a_data_i = 12'h777; a2b1_ce_n_i = 1'b0; a2b2_ce_n_i = 1'b1;
    tick(); check_model("R2");
    a_data_i = 12'h888; a2b1_ce_n_i = 1'b1; a2b2_ce_n_i = 1'b0;
    tick(); check_model("R3");
    a_data_i = 12'h999; a2b1_ce_n_i = 1'b0; a2b2_ce_n_i = 1'b1;
    tick(); check_model("R2");
    a2b1_ce_n_i = 1'b1; a2b2_ce_n_i = 1'b1;
  endtask

  // R5: hold with enables high on every path
  task automatic t_hold();
    logic [11:0] h1, h2, ha;
    h1 = b1_data_o; h2 = b2_data_o; ha = a_data_o;
    idle_inputs();
    b_oe_n_i = 1'b0;
    half_sel_i = m_sel;
    for (int k = 0; k < 3; k++) begin
      a_data_i = 12'hF0F ^ 12'(k); b1_data_i = 12'h5A5 + 12'(k); b2_data_i = 12'h3C3 - 12'(k);
      tick();
      chk("R5", "b1 held", b1_data_o, h1);
      chk("R5", "b2 held", b2_data_o, h2);
      chk("R5", "a held", a_data_o, ha);
    end
  endtask

  // R6 R7: return path and registered select
  task automatic t_return();
    a_oe_n_i = 1'b0;
    b1_data_i = 12'h123; b2_data_i = 12'hABC;
    b2a1_ce_n_i = 1'b0; b2a2_ce_n_i = 1'b0; half_sel_i = 1'b0;
    tick();
    chk("R6", "a from 1B", a_data_o, 12'h123);
    check_model("R6");
    b2a1_ce_n_i = 1'b1; b2a2_ce_n_i = 1'b1; b1_data_i = 12'h000; b2_data_i = 12'h000;
    half_sel_i = 1'b1;
    #2;
    chk("R7", "select not yet taken", a_data_o, 12'h123);
    tick();
    chk("R7", "a from 2B", a_data_o, 12'hABC);
    b1_data_i = 12'h456; b2a1_ce_n_i = 1'b0;
    tick();
    chk("R6", "hidden 1B still selects 2B", a_data_o, 12'hABC);
    b2a1_ce_n_i = 1'b1; half_sel_i = 1'b0;
    tick();
    chk("R7", "back to 1B", a_data_o, 12'h456);
    b2_data_i = 12'hDEF; b2a2_ce_n_i = 1'b0;
    tick();
    chk("R6", "2B loaded while 1B selected", a_data_o, 12'h456);
    b2a2_ce_n_i = 1'b1; half_sel_i = 1'b1;
    tick();
    chk("R7", "2B new value", a_data_o, 12'hDEF);
    check_model("R7");
  endtask

  // R8: registered output enables
  task automatic t_oe();
    a_oe_n_i = 1'b1; b_oe_n_i = 1'b1;
    tick(); check_model("R8");
    a_oe_n_i = 1'b0;
    #2;
    chk("R8", "a flag before edge", {11'd0, a_drive_o}, 12'd0);
    tick();
    chk("R8", "a flag after edge", {11'd0, a_drive_o}, 12'd1);
    chk("R8", "b1 flag stays off", {11'd0, b1_drive_o}, 12'd0);
    a_oe_n_i = 1'b1; b_oe_n_i = 1'b0;
    #2;
    chk("R8", "b flags before edge", {10'd0, b1_drive_o, b2_drive_o}, 12'd0);
    tick();
    chk("R8", "b flags after edge", {10'd0, b1_drive_o, b2_drive_o}, 12'd3);
    chk("R8", "a flag off", {11'd0, a_drive_o}, 12'd0);
    check_model("R8");
  endtask

  // R9: reset acts without a clock edge
  task automatic t_async_reset();
    a_data_i = 12'h6E1; a2b1_ce_n_i = 1'b0; a2b2_ce_n_i = 1'b0; a_oe_n_i = 1'b0;
    tick(); tick();
    #1;
    rst_ni = 1'b0;
    #1;
    check_all_zero("R9");
    idle_inputs();
    model_reset();
    #2;
    release_reset();
    check_model("R9");
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_pairing();
    t_hold();
    t_return();
    t_oe();
    t_async_reset();
    summary();
  end
endmodule